// File: doc/BRIEF.md
# Program Memory Table Read Unit

This unit carries out the lookup step of a small 8-bit controller core that fetches constant data out of its own 1024 x 14-bit program store. The core hands it a read command that names a destination location in data memory and selects one of two page modes. Either the page comes from the upper two bits of the program counter, or the top page (page 3) is forced. The low eight address bits always come from a byte-wide pointer register that software sets beforehand.

Each command takes two cycles. The low byte of the fetched word goes out on a data-memory write port toward the named location. The remaining six bits of the word are kept in a read-only high-byte register, where software can read them back. Both registers sit on a small register access port at fixed addresses. A load port lets the environment fill the program store, which is a plain synthesizable array.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the pointer register and the high-byte register both read 00h, and busy, done and dm_wr_en are low.
- R2: The pointer register sits at register address 07h. A write there (reg_wr_en high at a clock edge) sets it, and reg_rdata shows it when reg_addr is 07h.
- R3: The high-byte register sits at register address 08h and is read-only, so a register write to 08h leaves its value unchanged. Any register address other than 07h or 08h reads 00h.
- R4: With cmd_last = 0 (current page), the word fetched is the one at address {pc_page[1:0], pointer[7:0]}.
- R5: With cmd_last = 1 (last page), the word fetched is the one at address {2'b11, pointer[7:0]}, whatever pc_page holds.
- R6: A command is accepted at a clock edge where cmd_valid is high and the unit is idle. busy is then high for exactly the next two cycles. done and dm_wr_en are high only in the second of those cycles, with dm_wr_addr equal to cmd_dest and dm_wr_data equal to word bits 7:0.
- R7: From the cycle after done, register address 08h reads {2'b00, word bits 13:8}. Bits 7:6 always read 0.
- R8: A command presented while busy is high is ignored. It produces no extra done pulse, and busy is low in the cycle after done.
- R9: The pointer value, pc_page and cmd_dest are taken at the accepting edge. Later changes to them, including a pointer write during busy, do not affect the result of that read.
- R10: A clock edge with pm_ld_en high stores pm_ld_data at pm_ld_addr in the program store. A later read of that address returns the new word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Table read request |
| cmd_last | input | 1 | 1 = top page, 0 = current page |
| cmd_dest | input | 8 | Destination data-memory address |
| pc_page | input | 2 | Program counter bits 9:8 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pm_ld_en | input | 1 | Program store load strobe |
| pm_ld_addr | input | 10 | Program store load address |
| pm_ld_data | input | 14 | Program store load word |
| busy | output | 1 | Read in progress |
| done | output | 1 | Completion pulse |
| dm_wr_en | output | 1 | Data-memory write enable |
| dm_wr_addr | output | 8 | Data-memory write address |
| dm_wr_data | output | 8 | Data-memory write data |

## Verification
The hardest situation to reach from the ports is a read whose inputs change while it is in flight. In that case a second command arrives in each of the two busy cycles, the program counter page moves, and the pointer is rewritten, all before the first result lands. The stimulus holds cmd_valid high through both busy cycles with a different destination and changes pc_page and the pointer at the same time. It then checks that only one completion appears, carrying the originally captured address and destination, that busy drops right after it, and that the pointer read-back shows the new value. Boundary pointers 00h and FFh and all-ones and all-zeros words are placed in the store on purpose, so that page selection and the zero top bits of the high-byte register are both exercised.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
    parameter int PM_AW  = 10;
    parameter int PM_DW  = 14;
    parameter int BYTE_W = 8;
    parameter int DM_AW  = 8;
    parameter int REG_AW = 8;

    localparam int PAGE_W = PM_AW - BYTE_W;
    localparam int HI_W   = PM_DW - BYTE_W;

    localparam logic [REG_AW-1:0] PTR_REG_ADDR = REG_AW'(8'h07);
    localparam logic [REG_AW-1:0] HI_REG_ADDR  = REG_AW'(8'h08);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WRITE = 2'd2
    } tr_state_e;
endpackage

// File: rtl/tblrd_addr_gen.sv
module tblrd_addr_gen #(
    parameter int PM_AW  = 10,
    parameter int BYTE_W = 8,
    localparam int PAGE_W = PM_AW - BYTE_W
) (
    input  logic              sel_last,
    input  logic [PAGE_W-1:0] pc_page,
    input  logic [BYTE_W-1:0] ptr,
    output logic [PM_AW-1:0]  addr
);
    logic [PAGE_W-1:0] page;

    always_comb begin
        page = sel_last ? {PAGE_W{1'b1}} : pc_page;
        addr = {page, ptr};
    end
endmodule

// File: rtl/tblrd_prog_mem.sv
module tblrd_prog_mem #(
    parameter int PM_AW = 10,
    parameter int PM_DW = 14,
    localparam int DEPTH = 1 << PM_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [PM_AW-1:0] ld_addr,
    input  logic [PM_DW-1:0] ld_data,
    input  logic             rd_en,
    input  logic [PM_AW-1:0] rd_addr,
    output logic [PM_DW-1:0] rd_data
);
    logic [PM_DW-1:0] store [DEPTH];
    logic [PM_DW-1:0] rd_data_d, rd_data_q;

    always_ff @(posedge clk) begin
        if (ld_en) begin
            store[ld_addr] <= ld_data;
        end
    end

    always_comb begin
        rd_data_d = rd_data_q;
        if (rd_en) begin
            rd_data_d = store[rd_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_data_d;
    end

    assign rd_data = rd_data_q;

    // Output word only moves on a read cycle (R10 path integrity)
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data_q));
endmodule

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
    import tblrd_pkg::*;
#(
    parameter int PM_AW = 10,
    parameter int DM_AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [DM_AW-1:0] cmd_dest,
    input  logic [PM_AW-1:0] cmd_addr,
    output logic             rd_en,
    output logic [PM_AW-1:0] rd_addr,
    output logic             busy,
    output logic             done,
    output logic [DM_AW-1:0] dest
);
    typedef struct packed {
        tr_state_e        state;
        logic [PM_AW-1:0] addr;
        logic [DM_AW-1:0] dest;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    c_d.state = ST_FETCH;
                    c_d.addr  = cmd_addr;
                    c_d.dest  = cmd_dest;
                end
            end
            ST_FETCH: c_d.state = ST_WRITE;
            ST_WRITE: c_d.state = ST_IDLE;
            default:  c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
            c_q.addr  <= '0;
            c_q.dest  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_en   = (c_q.state == ST_FETCH);
    assign rd_addr = c_q.addr;
    assign busy    = (c_q.state != ST_IDLE);
    assign done    = (c_q.state == ST_WRITE);
    assign dest    = c_q.dest;

    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_idle_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    assert_capture_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(rd_addr) && $stable(dest)));
endmodule

// File: rtl/tblrd_regs.sv
module tblrd_regs
    import tblrd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int HI_W   = 6,
    parameter int REG_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              hi_upd,
    input  logic [HI_W-1:0]   hi_in,
    output logic [BYTE_W-1:0] ptr,
    output logic [BYTE_W-1:0] rdata
);
    typedef struct packed {
        logic [BYTE_W-1:0] ptr;
        logic [HI_W-1:0]   hi;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && addr == PTR_REG_ADDR) begin
            r_d.ptr = wdata;
        end
        if (hi_upd) begin
            r_d.hi = hi_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if (addr == PTR_REG_ADDR)     rdata = r_q.ptr;
        else if (addr == HI_REG_ADDR) rdata = BYTE_W'(r_q.hi);
        else                          rdata = '0;
    end

    assign ptr = r_q.ptr;

    assert_hi_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == HI_REG_ADDR && !hi_upd) |=> $stable(r_q.hi));
    assert_hi_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_upd |=> $stable(r_q.hi));
    assert_ptr_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == PTR_REG_ADDR) |=> (r_q.ptr == $past(wdata)));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
    import tblrd_pkg::*;
#(
    parameter int PM_AW  = tblrd_pkg::PM_AW,
    parameter int PM_DW  = tblrd_pkg::PM_DW,
    parameter int BYTE_W = tblrd_pkg::BYTE_W,
    parameter int DM_AW  = tblrd_pkg::DM_AW,
    parameter int REG_AW = tblrd_pkg::REG_AW,
    localparam int PG_W  = PM_AW - BYTE_W,
    localparam int HB_W  = PM_DW - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_last,
    input  logic [DM_AW-1:0]  cmd_dest,
    input  logic [PG_W-1:0]   pc_page,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              pm_ld_en,
    input  logic [PM_AW-1:0]  pm_ld_addr,
    input  logic [PM_DW-1:0]  pm_ld_data,
    output logic              busy,
    output logic              done,
    output logic              dm_wr_en,
    output logic [DM_AW-1:0]  dm_wr_addr,
    output logic [BYTE_W-1:0] dm_wr_data
);
    logic [BYTE_W-1:0] ptr;
    logic [PM_AW-1:0]  cmd_addr;
    logic              rd_en;
    logic [PM_AW-1:0]  rd_addr;
    logic [PM_DW-1:0]  word;

    tblrd_addr_gen #(.PM_AW(PM_AW), .BYTE_W(BYTE_W)) i_addr (
        .sel_last (cmd_last),
        .pc_page  (pc_page),
        .ptr      (ptr),
        .addr     (cmd_addr)
    );

    tblrd_ctrl #(.PM_AW(PM_AW), .DM_AW(DM_AW)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_dest  (cmd_dest),
        .cmd_addr  (cmd_addr),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .done      (done),
        .dest      (dm_wr_addr)
    );

    tblrd_prog_mem #(.PM_AW(PM_AW), .PM_DW(PM_DW)) i_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (pm_ld_en),
        .ld_addr (pm_ld_addr),
        .ld_data (pm_ld_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (word)
    );

    tblrd_regs #(.BYTE_W(BYTE_W), .HI_W(HB_W), .REG_AW(REG_AW)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .hi_upd (done),
        .hi_in  (word[PM_DW-1:BYTE_W]),
        .ptr    (ptr),
        .rdata  (reg_rdata)
    );

    assign dm_wr_en   = done;
    assign dm_wr_data = word[BYTE_W-1:0];

    assert_last_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_last && !busy) |=> (rd_addr[PM_AW-1:BYTE_W] == {PG_W{1'b1}}));
    assert_cur_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_last && !busy) |=> (rd_addr[PM_AW-1:BYTE_W] == $past(pc_page)));
    assert_ptr_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> (rd_addr[BYTE_W-1:0] == $past(ptr)));
endmodule

// File: tb/test_tblrd_unit.sv
module test_tblrd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_last = 1'b0;
    logic [7:0]  cmd_dest = '0;
    logic [1:0]  pc_page = '0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0, reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        pm_ld_en = 1'b0;
    logic [9:0]  pm_ld_addr = '0;
    logic [13:0] pm_ld_data = '0;
    logic        busy, done, dm_wr_en;
    logic [7:0]  dm_wr_addr, dm_wr_data;

    int checks = 0, failures = 0, done_seen = 0, done_expected = 0;
    logic [13:0] model [1024];

    typedef struct packed { logic [7:0] dest; logic [7:0] data; } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    tblrd_unit i_tblrd_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_last(cmd_last),
        .cmd_dest(cmd_dest), .pc_page(pc_page), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pm_ld_en(pm_ld_en), .pm_ld_addr(pm_ld_addr), .pm_ld_data(pm_ld_data),
        .busy(busy), .done(done), .dm_wr_en(dm_wr_en),
        .dm_wr_addr(dm_wr_addr), .dm_wr_data(dm_wr_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every completion pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_seen++;
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(dm_wr_en == 1'b1, "R6 dm_wr_en with done", int'(dm_wr_en), 1);
                check(dm_wr_addr == e.dest, "R6 dm_wr_addr", int'(dm_wr_addr), int'(e.dest));
                check(dm_wr_data == e.data, "R6 dm_wr_data", int'(dm_wr_data), int'(e.data));
            end
        end
    end

    task automatic load_word(input logic [9:0] a, input logic [13:0] w);
        @(negedge clk);
        pm_ld_en = 1'b1; pm_ld_addr = a; pm_ld_data = w;
        model[a] = w;
        @(negedge clk);
        pm_ld_en = 1'b0;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Driver: issue one read, push the expected item, check timing and high byte
    task automatic do_read(input logic last, input logic [7:0] dest,
                           input logic [1:0] page, input logic [7:0] ptrv, input string tag);
        logic [9:0] a;
        logic [7:0] hv;
        a = {(last ? 2'b11 : page), ptrv};
        sb.push_back({dest, model[a][7:0]});
        done_expected++;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_last = last; cmd_dest = dest; pc_page = page;
        @(negedge clk);
        cmd_valid = 1'b0; pc_page = ~page;
        check(busy && !done, {tag, " R6 first cycle"}, int'({busy, done}), 2);
        @(negedge clk);
        check(busy && done, {tag, " R6 second cycle"}, int'({busy, done}), 3);
        @(negedge clk);
        check(!busy, {tag, " R8 idle after done"}, int'(busy), 0);
        read_reg(8'h08, hv);
        check(hv == {2'b00, model[a][13:8]}, {tag, " R7 high byte"}, int'(hv),
              int'({2'b00, model[a][13:8]}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !dm_wr_en, "R1 outputs idle", int'({busy, done, dm_wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(8'h07, v); check(v == 8'h00, "R1 pointer reset", int'(v), 0);
        read_reg(8'h08, v); check(v == 8'h00, "R1 high reset", int'(v), 0);

        // R10 fill the store with a computed pattern
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            pm_ld_en = 1'b1; pm_ld_addr = 10'(i);
            pm_ld_data = 14'((i * 2731 + 113) ^ (i << 4));
            model[i] = pm_ld_data;
        end
        @(negedge clk);
        pm_ld_en = 1'b0;
        load_word(10'h0FF, 14'h3FFF);
        load_word(10'h3FF, 14'h0000);
        load_word(10'h300, 14'h2A55);

        // R2 pointer register
        write_reg(8'h07, 8'h5A);
        read_reg(8'h07, v); check(v == 8'h5A, "R2 pointer readback", int'(v), 8'h5A);

        // R4 current page reads on several pages
        do_read(1'b0, 8'h20, 2'd0, 8'h5A, "R4 page0");
        do_read(1'b0, 8'h21, 2'd1, 8'h5A, "R4 page1");
        do_read(1'b0, 8'h22, 2'd2, 8'h5A, "R4 page2");
        write_reg(8'h07, 8'hFF);
        do_read(1'b0, 8'h23, 2'd0, 8'hFF, "R4 ptrFF allones");
        read_reg(8'h08, v); check(v[7:6] == 2'b00, "R7 top bits zero", int'(v), 8'h3F);

        // R5 last page forced regardless of pc_page
        do_read(1'b1, 8'h24, 2'd0, 8'hFF, "R5 last ptrFF");
        write_reg(8'h07, 8'h00);
        do_read(1'b1, 8'h25, 2'd1, 8'h00, "R5 last ptr00");

        // R3 high register is read-only; unmapped address reads zero
        write_reg(8'h08, 8'hFF);
        read_reg(8'h08, v);
        check(v == {2'b00, model[10'h300][13:8]}, "R3 high write ignored", int'(v),
              int'({2'b00, model[10'h300][13:8]}));
        read_reg(8'h05, v); check(v == 8'h00, "R3 unmapped reads zero", int'(v), 0);

        // R8 and R9: commands and input changes during busy
        write_reg(8'h07, 8'h3C);
        begin
            logic [9:0] a;
            a = {2'd2, 8'h3C};
            sb.push_back({8'h30, model[a][7:0]});
            done_expected++;
            @(negedge clk);
            cmd_valid = 1'b1; cmd_last = 1'b0; cmd_dest = 8'h30; pc_page = 2'd2;
            @(negedge clk);
            cmd_dest = 8'h31; cmd_last = 1'b1; pc_page = 2'd0;
            reg_wr_en = 1'b1; reg_addr = 8'h07; reg_wdata = 8'h99;
            @(negedge clk);
            reg_wr_en = 1'b0;
            cmd_dest = 8'h32;
            @(negedge clk);
            cmd_valid = 1'b0;
            check(!busy, "R8 second command ignored", int'(busy), 0);
            read_reg(8'h08, v);
            check(v == {2'b00, model[a][13:8]}, "R9 captured address high", int'(v),
                  int'({2'b00, model[a][13:8]}));
            read_reg(8'h07, v); check(v == 8'h99, "R9 pointer written while busy", int'(v), 8'h99);
        end

        // R10 reload a word and read it again
        load_word(10'h199, 14'h1234);
        do_read(1'b0, 8'h40, 2'd1, 8'h99, "R10 reloaded word");

        repeat (4) @(negedge clk);
        check(done_seen == done_expected, "R8 completion count", done_seen, done_expected);
        check(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule